// File: doc/BRIEF.md
# Serial Programming Port with Two-Step Bulk Erase Unlock

This block is the device-side engine of a synchronous serial programming port. An external programmer frames each 32-bit command word by holding a frame line high and clocking the bits in most significant first on a serial clock. While each command bit goes in, one bit of the response word left by the previous command comes out. When the frame line drops, two more serial clock pulses start the decoded operation. The data-out line then becomes a ready/busy handshake. It goes low while the operation runs and high again when it ends.

Commands write a single byte to either the code or the data memory. A special bulk-erase form fills every even 16-byte code page, or every odd one, with a chosen byte. Bulk erase works even while the volatile write-disable bit is set. Once both halves have been erased in the current programming session, the volatile protection register (write-disable and read-disable) is cleared. This lets the erased device be reprogrammed without exposing the old code. The memories themselves sit outside the block and are reached through registered single-byte write ports. All serial inputs are synchronised into the system clock domain, and serial clock edges are handled as sampled events.

Top module: `serprog_port`

## Requirements
- R1: A command is exactly 32 bits shifted in MSB first on `pdi` at rising `pclk` edges while `pframe` is high. A frame that ends with any other bit count is discarded: it runs no operation and leaves the pending response word unchanged.
- R2: During the shift, the response word of the previous command appears on `pdo`, bit 31 after the first rising edge and one bit per edge after that. Bits 31:8 echo bits 31:8 of that command. Bit 0 is set if it was rejected, bit 1 holds the even-half-done flag, bit 2 the odd-half-done flag, bit 3 the volatile write-disable and bit 4 the volatile read-disable, and bits 7:5 are zero. The first response after entering programming mode is all zeros.
- R3: After `pframe` falls on a full 32-bit frame, the second rising `pclk` edge starts the operation and drives `pdo` low. `pdo` stays low for the whole operation (WRITE_CYCLES system cycles for a byte command) and then returns high.
- R4: `pclk` edges that arrive while the operation is busy have no effect on memory, protection or the next response.
- R5: A command with bit 22 clear is a byte write of bits 7:0. It goes to code memory when bit 28 is set and to data memory when bit 28 is clear, at the address in bits 17:8 (low bits used).
- R6: A code-memory byte write is suppressed while volatile write-disable is set, and its response carries the reject bit. A data-memory write is never suppressed.
- R7: A command with bits 22 and 28 set and address field 0x000 writes its data byte into every byte of every even page (code address bit 4 = 0). With address field 0x010 it fills every odd page (bit 4 = 1). Erase runs regardless of write-disable and never writes data memory.
- R8: A command with bit 22 set that is not one of the two erase forms (other address, or bit 28 clear) is rejected: no memory change, and the reject bit is set in its response.
- R9: Both volatile protection bits are cleared once both the even-half and odd-half erase have completed in the current session, in either order. After a single half they stay set.
- R10: While `prog_en` is low the volatile protection bits follow `init_wdis`/`init_rdis`, both half-done flags are cleared and `pdo` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Programming mode active (system clock domain) |
| init_wdis | input | 1 | Non-volatile write-disable value loaded outside programming mode |
| init_rdis | input | 1 | Non-volatile read-disable value loaded outside programming mode |
| pclk | input | 1 | Serial clock from the programmer (asynchronous) |
| pdi | input | 1 | Serial command data in |
| pframe | input | 1 | Command frame, high while shifting |
| pdo | output | 1 | Response data out, then ready (high) / busy (low) |
| vol_wdis | output | 1 | Volatile write-disable bit |
| vol_rdis | output | 1 | Volatile read-disable bit |
| code_we | output | 1 | Code memory byte write strobe |
| code_addr | output | CODE_AW | Code memory byte address |
| code_wdata | output | 8 | Code memory write byte |
| data_we | output | 1 | Data memory byte write strobe |
| data_addr | output | DATA_AW | Data memory byte address |
| data_wdata | output | 8 | Data memory write byte |

## Verification
The end of the second half-erase and a stray serial clock edge can fall in the same system cycle. In that cycle the unlock clears the protection bits, builds the response word and returns `pdo` high, while the edge detector fires for a serial pulse the programmer should not have sent. The bench keeps toggling `pclk` at a short period throughout every erase, so that edges land on and around the completion cycle. It then judges the outcome from the ports: the full memory image, the protection outputs, and the exact response word read back by the following command.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int CMD_W       = 32;
  localparam int BYTE_W      = 8;
  localparam int ADDR_FLD_W  = 10;
  localparam int ADDR_FLD_LO = 8;
  localparam int CODE_SEL_B  = 28;
  localparam int ERASE_B     = 22;

  localparam logic [ADDR_FLD_W-1:0] SEL_EVEN_HALF = 10'h000;
  localparam logic [ADDR_FLD_W-1:0] SEL_ODD_HALF  = 10'h010;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_TAIL  = 3'd2,
    ST_WRITE = 3'd3,
    ST_ERASE = 3'd4
  } pp_state_e;

  typedef struct packed {
    logic [CMD_W-1:BYTE_W] echo;
    logic [2:0]            zero;
    logic                  rdis;
    logic                  wdis;
    logic                  odd_done;
    logic                  even_done;
    logic                  reject;
  } pp_resp_t;

endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/serprog_shift.sv
module serprog_shift
  import serprog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CMD_W-1:0] resp_i,
  input  logic             shift_i,
  input  logic             sdi_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             full_o,
  output logic             out_bit_o
);

  localparam int CNT_W = $clog2(CMD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CMD_W + 1);

  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] rsp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      rsp_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      cmd_q <= '0;
      rsp_q <= resp_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      cmd_q <= {cmd_q[CMD_W-2:0], sdi_i};
      rsp_q <= {rsp_q[CMD_W-2:0], 1'b0};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cmd_o     = cmd_q;
  assign full_o    = (cnt_q == CNT_FULL);
  assign out_bit_o = rsp_q[CMD_W-1];

endmodule

// File: rtl/serprog_eraseq.sv
module serprog_eraseq #(
  parameter int CODE_AW = 10,
  parameter int PAGE_AW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               abort_i,
  input  logic               start_i,
  input  logic               parity_i,
  output logic [CODE_AW-1:0] addr_o,
  output logic               last_o,
  output logic               parity_o
);

  localparam int HALF_AW = CODE_AW - 1;

  logic [HALF_AW-1:0] idx_q;
  logic               par_q;
  logic               act_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      idx_q <= '0;
      par_q <= 1'b0;
      act_q <= 1'b0;
    end else if (start_i) begin
      idx_q <= '0;
      par_q <= parity_i;
      act_q <= 1'b1;
    end else if (act_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == '1) act_q <= 1'b0;
    end
  end

  // page bit sits directly above the in-page offset; the index supplies the rest
  assign addr_o   = {idx_q[HALF_AW-1:PAGE_AW], par_q, idx_q[PAGE_AW-1:0]};
  assign last_o   = act_q && (idx_q == '1);
  assign parity_o = par_q;

endmodule

// File: rtl/serprog_ctrl.sv
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int CODE_AW      = 10,
  parameter int DATA_AW      = 6,
  parameter int WRITE_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_en_i,
  input  logic               init_wdis_i,
  input  logic               init_rdis_i,
  input  logic               frame_i,
  input  logic               rise_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               full_i,
  input  logic               out_bit_i,
  output logic               sh_load_o,
  output logic               sh_shift_o,
  output logic [CMD_W-1:0]   resp_o,
  output logic               ers_start_o,
  output logic               ers_parity_o,
  input  logic [CODE_AW-1:0] ers_addr_i,
  input  logic               ers_last_i,
  input  logic               ers_parity_i,
  output logic               pdo_o,
  output logic               vol_wdis_o,
  output logic               vol_rdis_o,
  output logic               even_o,
  output logic               odd_o,
  output logic               busy_o,
  output logic               erase_o,
  output logic               code_we_o,
  output logic [CODE_AW-1:0] code_addr_o,
  output logic [BYTE_W-1:0]  code_wdata_o,
  output logic               data_we_o,
  output logic [DATA_AW-1:0] data_addr_o,
  output logic [BYTE_W-1:0]  data_wdata_o
);

  localparam int BCW = $clog2(WRITE_CYCLES + 1);
  localparam logic [BCW-1:0] BUSY_LOAD = BCW'(WRITE_CYCLES - 1);

  pp_state_e            state_q;
  logic [BCW-1:0]       bcnt_q;
  logic                 tail_q;
  logic                 pdo_q;
  logic                 reject_q;
  logic                 even_q, odd_q;
  logic                 wdis_q, rdis_q;
  logic [CMD_W-1:0]     resp_q;
  logic                 code_we_q, data_we_q;
  logic [CODE_AW-1:0]   code_addr_q;
  logic [DATA_AW-1:0]   data_addr_q;
  logic [BYTE_W-1:0]    code_wdata_q, data_wdata_q;

  // command field decode
  logic                  f_code, f_erase;
  logic [ADDR_FLD_W-1:0] f_addr;
  logic [BYTE_W-1:0]     f_byte;
  logic                  ers_even, ers_odd, ers_bad, wr_locked;
  logic                  go;

  always_comb begin
    f_code    = cmd_i[CODE_SEL_B];
    f_erase   = cmd_i[ERASE_B];
    f_addr    = cmd_i[ADDR_FLD_LO +: ADDR_FLD_W];
    f_byte    = cmd_i[BYTE_W-1:0];
    ers_even  = f_code && f_erase && (f_addr == SEL_EVEN_HALF);
    ers_odd   = f_code && f_erase && (f_addr == SEL_ODD_HALF);
    ers_bad   = f_erase && !ers_even && !ers_odd;
    wr_locked = f_code && !f_erase && wdis_q;
    go        = (state_q == ST_TAIL) && !frame_i && rise_i && tail_q;
  end

  // completion bookkeeping for the two-step unlock
  logic     fin_erase, fin_write, finish;
  logic     even_n, odd_n, unlock, wdis_n, rdis_n;
  pp_resp_t rsp_n;

  always_comb begin
    fin_erase = (state_q == ST_ERASE) && ers_last_i;
    fin_write = (state_q == ST_WRITE) && (bcnt_q == '0);
    finish    = fin_erase || fin_write;
    even_n    = even_q || (fin_erase && !ers_parity_i);
    odd_n     = odd_q  || (fin_erase &&  ers_parity_i);
    unlock    = even_n && odd_n;
    wdis_n    = wdis_q && !unlock;
    rdis_n    = rdis_q && !unlock;
    rsp_n.echo      = cmd_i[CMD_W-1:BYTE_W];
    rsp_n.zero      = '0;
    rsp_n.rdis      = rdis_n;
    rsp_n.wdis      = wdis_n;
    rsp_n.odd_done  = odd_n;
    rsp_n.even_done = even_n;
    rsp_n.reject    = reject_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !prog_en_i) begin
      state_q      <= ST_IDLE;
      bcnt_q       <= '0;
      tail_q       <= 1'b0;
      pdo_q        <= 1'b1;
      reject_q     <= 1'b0;
      even_q       <= 1'b0;
      odd_q        <= 1'b0;
      wdis_q       <= init_wdis_i;
      rdis_q       <= init_rdis_i;
      resp_q       <= '0;
      code_we_q    <= 1'b0;
      data_we_q    <= 1'b0;
      code_addr_q  <= '0;
      data_addr_q  <= '0;
      code_wdata_q <= '0;
      data_wdata_q <= '0;
    end else begin
      code_we_q <= 1'b0;
      data_we_q <= 1'b0;
      even_q    <= even_n;
      odd_q     <= odd_n;
      wdis_q    <= wdis_n;
      rdis_q    <= rdis_n;

      unique case (state_q)
        ST_IDLE: begin
          if (frame_i) state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!frame_i) begin
            tail_q  <= 1'b0;
            state_q <= full_i ? ST_TAIL : ST_IDLE;
          end else if (rise_i) begin
            pdo_q <= out_bit_i;
          end
        end
        ST_TAIL: begin
          if (frame_i) begin
            state_q <= ST_IDLE;
          end else if (rise_i && !tail_q) begin
            tail_q <= 1'b1;
          end else if (go) begin
            pdo_q    <= 1'b0;
            reject_q <= ers_bad || wr_locked;
            if (ers_even || ers_odd) begin
              state_q <= ST_ERASE;
            end else begin
              state_q <= ST_WRITE;
              bcnt_q  <= BUSY_LOAD;
              if (!ers_bad && !wr_locked) begin
                if (f_code) begin
                  code_we_q    <= 1'b1;
                  code_addr_q  <= f_addr[CODE_AW-1:0];
                  code_wdata_q <= f_byte;
                end else begin
                  data_we_q    <= 1'b1;
                  data_addr_q  <= f_addr[DATA_AW-1:0];
                  data_wdata_q <= f_byte;
                end
              end
            end
          end
        end
        ST_WRITE: begin
          if (bcnt_q != '0) bcnt_q <= bcnt_q - 1'b1;
        end
        ST_ERASE: begin
          code_we_q    <= 1'b1;
          code_addr_q  <= ers_addr_i;
          code_wdata_q <= f_byte;
        end
        default: state_q <= ST_IDLE;
      endcase

      if (finish) begin
        pdo_q   <= 1'b1;
        resp_q  <= rsp_n;
        state_q <= ST_IDLE;
      end
    end
  end

  assign sh_load_o    = (state_q == ST_IDLE) && frame_i;
  assign sh_shift_o   = (state_q == ST_SHIFT) && frame_i && rise_i;
  assign resp_o       = resp_q;
  assign ers_start_o  = go && (ers_even || ers_odd);
  assign ers_parity_o = ers_odd;
  assign pdo_o        = pdo_q;
  assign vol_wdis_o   = wdis_q;
  assign vol_rdis_o   = rdis_q;
  assign even_o       = even_q;
  assign odd_o        = odd_q;
  assign busy_o       = (state_q == ST_WRITE) || (state_q == ST_ERASE);
  assign erase_o      = (state_q == ST_ERASE);
  assign code_we_o    = code_we_q;
  assign code_addr_o  = code_addr_q;
  assign code_wdata_o = code_wdata_q;
  assign data_we_o    = data_we_q;
  assign data_addr_o  = data_addr_q;
  assign data_wdata_o = data_wdata_q;

endmodule

// File: rtl/serprog_port.sv
module serprog_port
  import serprog_pkg::*;
#(
  parameter int CODE_BYTES   = 1024,
  parameter int PAGE_BYTES   = 16,
  parameter int DATA_BYTES   = 64,
  parameter int WRITE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2,
  localparam int CODE_AW     = $clog2(CODE_BYTES),
  localparam int DATA_AW     = $clog2(DATA_BYTES),
  localparam int PAGE_AW     = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_en,
  input  logic               init_wdis,
  input  logic               init_rdis,
  input  logic               pclk,
  input  logic               pdi,
  input  logic               pframe,
  output logic               pdo,
  output logic               vol_wdis,
  output logic               vol_rdis,
  output logic               code_we,
  output logic [CODE_AW-1:0] code_addr,
  output logic [7:0]         code_wdata,
  output logic               data_we,
  output logic [DATA_AW-1:0] data_addr,
  output logic [7:0]         data_wdata
);

  logic [2:0]         sync_q;
  logic               pclk_s, pdi_s, frame_s, pclk_d, rise_w;
  logic               sh_load_w, sh_shift_w, full_w, out_bit_w;
  logic [CMD_W-1:0]   cmd_w, resp_w;
  logic               ers_start_w, ers_par_in_w, ers_last_w, ers_parity_w;
  logic [CODE_AW-1:0] ers_addr_w;
  logic               even_w, odd_w, busy_w, erase_w;

  serprog_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({pclk, pdi, pframe}),
    .q_o (sync_q)
  );

  assign {pclk_s, pdi_s, frame_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) pclk_d <= 1'b0;
    else     pclk_d <= pclk_s;
  end
  assign rise_w = pclk_s && !pclk_d;

  serprog_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (sh_load_w),
    .resp_i    (resp_w),
    .shift_i   (sh_shift_w),
    .sdi_i     (pdi_s),
    .cmd_o     (cmd_w),
    .full_o    (full_w),
    .out_bit_o (out_bit_w)
  );

  serprog_eraseq #(.CODE_AW(CODE_AW), .PAGE_AW(PAGE_AW)) u_eraseq (
    .clk      (clk),
    .rst      (rst),
    .abort_i  (!prog_en),
    .start_i  (ers_start_w),
    .parity_i (ers_par_in_w),
    .addr_o   (ers_addr_w),
    .last_o   (ers_last_w),
    .parity_o (ers_parity_w)
  );

  serprog_ctrl #(
    .CODE_AW      (CODE_AW),
    .DATA_AW      (DATA_AW),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .prog_en_i    (prog_en),
    .init_wdis_i  (init_wdis),
    .init_rdis_i  (init_rdis),
    .frame_i      (frame_s),
    .rise_i       (rise_w),
    .cmd_i        (cmd_w),
    .full_i       (full_w),
    .out_bit_i    (out_bit_w),
    .sh_load_o    (sh_load_w),
    .sh_shift_o   (sh_shift_w),
    .resp_o       (resp_w),
    .ers_start_o  (ers_start_w),
    .ers_parity_o (ers_par_in_w),
    .ers_addr_i   (ers_addr_w),
    .ers_last_i   (ers_last_w),
    .ers_parity_i (ers_parity_w),
    .pdo_o        (pdo),
    .vol_wdis_o   (vol_wdis),
    .vol_rdis_o   (vol_rdis),
    .even_o       (even_w),
    .odd_o        (odd_w),
    .busy_o       (busy_w),
    .erase_o      (erase_w),
    .code_we_o    (code_we),
    .code_addr_o  (code_addr),
    .code_wdata_o (code_wdata),
    .data_we_o    (data_we),
    .data_addr_o  (data_addr),
    .data_wdata_o (data_wdata)
  );

endmodule

// File: rtl/serprog_chk.sv
module serprog_chk #(
  parameter int CODE_AW = 10,
  parameter int PAGE_AW = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               prog_en,
  input logic               init_wdis,
  input logic               pdo,
  input logic               vol_wdis,
  input logic               code_we,
  input logic [CODE_AW-1:0] code_addr,
  input logic               data_we,
  input logic               busy,
  input logic               erasing,
  input logic               ers_parity,
  input logic               even_done,
  input logic               odd_done
);

  AST_BUSY_PDO_LOW: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pdo) else $error("pdo high while busy"); // R3

  AST_LOCKED_NO_CODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    code_we |-> ($past(erasing) || !$past(vol_wdis))) else $error("code write while locked"); // R6

  AST_ERASE_NO_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    erasing |-> !data_we) else $error("data write during erase"); // R7

  AST_ERASE_HALF_PARITY: assert property (@(posedge clk) disable iff (rst)
    (erasing && code_we) |-> (code_addr[PAGE_AW] == ers_parity)) else $error("erase hit wrong half"); // R7

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({code_we, data_we})) else $error("two write strobes"); // R5

  AST_UNLOCK_BOTH_HALVES: assert property (@(posedge clk) disable iff (rst)
    (prog_en && $past(prog_en) && $fell(vol_wdis)) |-> (even_done && odd_done)) else $error("unlock early"); // R9

  AST_OUT_OF_MODE: assert property (@(posedge clk) disable iff (rst)
    !prog_en |=> (pdo && (vol_wdis == $past(init_wdis)))) else $error("idle state wrong"); // R10

endmodule

bind serprog_port serprog_chk #(.CODE_AW(CODE_AW), .PAGE_AW(PAGE_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .prog_en    (prog_en),
  .init_wdis  (init_wdis),
  .pdo        (pdo),
  .vol_wdis   (vol_wdis),
  .code_we    (code_we),
  .code_addr  (code_addr),
  .data_we    (data_we),
  .busy       (busy_w),
  .erasing    (erase_w),
  .ers_parity (ers_parity_w),
  .even_done  (even_w),
  .odd_done   (odd_w)
);

// File: tb/serprog_port_tb.sv
module serprog_port_tb;

  localparam int CB = 1024;
  localparam int DB = 64;
  localparam int WC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_en = 1'b0;
  logic init_wdis = 1'b1;
  logic init_rdis = 1'b1;
  logic pclk = 1'b0, pdi = 1'b0, pframe = 1'b0;
  logic pdo, vol_wdis, vol_rdis, code_we, data_we;
  logic [9:0] code_addr;
  logic [5:0] data_addr;
  logic [7:0] code_wdata, data_wdata;

  logic [7:0] cmem [CB];
  logic [7:0] dmem [DB];
  logic [7:0] cexp [CB];
  logic [7:0] dexp [DB];

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serprog_port u_dut (
    .clk(clk), .rst(rst), .prog_en(prog_en), .init_wdis(init_wdis), .init_rdis(init_rdis),
    .pclk(pclk), .pdi(pdi), .pframe(pframe), .pdo(pdo), .vol_wdis(vol_wdis), .vol_rdis(vol_rdis),
    .code_we(code_we), .code_addr(code_addr), .code_wdata(code_wdata),
    .data_we(data_we), .data_addr(data_addr), .data_wdata(data_wdata)
  );

  always @(posedge clk) begin
    if (code_we) cmem[code_addr] <= code_wdata;
    if (data_we) dmem[data_addr] <= data_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rsp(input logic [31:0] w, input bit rej, input bit ev,
                                      input bit od, input bit wd, input bit rd);
    return {w[31:8], 3'b000, rd, wd, od, ev, rej};
  endfunction

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < CB; i++) if (cmem[i] !== cexp[i]) bad++;
    for (int i = 0; i < DB; i++) if (dmem[i] !== dexp[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift a frame of nbits; full frames get the two tail pulses and the busy wait
  task automatic send(input logic [31:0] w, input int nbits, input bit toggle,
                      output logic [31:0] r, output int busy);
    r = '0;
    busy = 0;
    pframe = 1'b1;
    ticks(6);
    for (int i = 0; i < nbits; i++) begin
      pdi = w[31-i];
      ticks(6);
      pclk = 1'b1;
      ticks(6);
      r = {r[30:0], pdo};
      pclk = 1'b0;
    end
    pframe = 1'b0;
    ticks(6);
    if (nbits == 32) begin
      pclk = 1'b1; ticks(6); pclk = 1'b0; ticks(6);
      pclk = 1'b1; ticks(5);
      chk(pdo === 1'b0, "R3 pdo low after second tail edge", pdo, 0);
      ticks(1);
      pclk = 1'b0;
      busy = 6;
      while (pdo !== 1'b1 && busy < 5000) begin
        ticks(1);
        busy++;
        if (toggle && (busy % 3 == 0)) pclk = ~pclk;
      end
      pclk = 1'b0;
    end
    ticks(8);
  endtask

  localparam logic [31:0] PROBE = 32'h0040_0000;

  task automatic t_reset();
    chk(pdo === 1'b1, "R10 pdo high out of mode", pdo, 1);
    chk(vol_wdis === 1'b1 && vol_rdis === 1'b1, "R10 protection loaded", {vol_rdis, vol_wdis}, 3);
  endtask

  task automatic t_data_write_then_locked();
    logic [31:0] r, wa, wb;
    int b;
    wa = {14'h0, 10'h005, 8'h3C};
    send(wa, 32, 0, r, b);
    chk(r === 32'h0, "R2 first response zero", r, 0);
    chk(b >= WC + 1 && b <= WC + 5, "R3 write busy length", b, WC + 3);
    dexp[5] = 8'h3C;
    mem_cmp("R5 data write");
    wb = 32'h1000_0000 | {14'h0, 10'h123, 8'hEE};
    send(wb, 32, 0, r, b);
    chk(r === rsp(wa, 0, 0, 0, 1, 1), "R2 echo response", r, rsp(wa, 0, 0, 0, 1, 1));
    mem_cmp("R6 locked code write suppressed");
    send(PROBE, 32, 0, r, b);
    chk(r === rsp(wb, 1, 0, 0, 1, 1), "R6 reject bit", r, rsp(wb, 1, 0, 0, 1, 1));
  endtask

  task automatic t_erase_sequence();
    logic [31:0] r, we, wo;
    int b;
    we = 32'h1040_00A5;
    send(we, 32, 1, r, b);
    for (int i = 0; i < CB; i++) if (((i >> 4) & 1) == 0) cexp[i] = 8'hA5;
    mem_cmp("R7 even half filled, R4 stray edges ignored");
    chk(vol_wdis === 1'b1, "R9 single half keeps lock", vol_wdis, 1);
    wo = 32'h1040_103E;
    send(wo, 31, 0, r, b);
    mem_cmp("R1 short frame discarded");
    send(wo, 32, 1, r, b);
    chk(r === rsp(we, 0, 1, 0, 1, 1), "R1 response kept across discard", r, rsp(we, 0, 1, 0, 1, 1));
    for (int i = 0; i < CB; i++) if (((i >> 4) & 1) == 1) cexp[i] = 8'h3E;
    mem_cmp("R7 odd half filled, R4 edge at completion");
    chk(vol_wdis === 1'b0 && vol_rdis === 1'b0, "R9 unlocked after both", {vol_rdis, vol_wdis}, 0);
    send(32'h1000_F377, 32, 0, r, b);
    chk(r === rsp(wo, 0, 1, 1, 0, 0), "R9 response after unlock", r, rsp(wo, 0, 1, 1, 0, 0));
    cexp[10'h0F3] = 8'h77;
    mem_cmp("R5 code write after unlock");
  endtask

  task automatic t_bad_erase();
    logic [31:0] r, wbad;
    int b;
    wbad = 32'h1040_2011;
    send(wbad, 32, 0, r, b);
    send(PROBE, 32, 0, r, b);
    chk(r === rsp(wbad, 1, 1, 1, 0, 0), "R8 bad erase rejected", r, rsp(wbad, 1, 1, 1, 0, 0));
    mem_cmp("R8 bad erase no memory change");
  endtask

  task automatic t_reenter_reverse_order();
    logic [31:0] r, wo, we;
    int b;
    prog_en = 1'b0;
    ticks(4);
    chk(vol_wdis === 1'b1 && vol_rdis === 1'b1, "R10 reload on exit", {vol_rdis, vol_wdis}, 3);
    chk(pdo === 1'b1, "R10 pdo high on exit", pdo, 1);
    prog_en = 1'b1;
    ticks(4);
    wo = 32'h1040_1010;
    send(wo, 32, 1, r, b);
    chk(r === 32'h0, "R2 first response after re-entry", r, 0);
    chk(vol_wdis === 1'b1, "R9 flags cleared on re-entry", vol_wdis, 1);
    we = 32'h1040_0020;
    send(we, 32, 1, r, b);
    for (int i = 0; i < CB; i++) cexp[i] = (((i >> 4) & 1) == 1) ? 8'h10 : 8'h20;
    mem_cmp("R7 both halves reverse order");
    chk(vol_wdis === 1'b0 && vol_rdis === 1'b0, "R9 odd-then-even unlock", {vol_rdis, vol_wdis}, 0);
    send(PROBE, 32, 0, r, b);
    chk(r === rsp(we, 0, 1, 1, 0, 0), "R2 flags in response", r, rsp(we, 0, 1, 1, 0, 0));
  endtask

  initial begin
    for (int i = 0; i < CB; i++) begin
      cmem[i] = 8'(i) ^ 8'h5A;
      cexp[i] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < DB; i++) begin
      dmem[i] = 8'(i + 1);
      dexp[i] = 8'(i + 1);
    end
    ticks(5);
    rst = 1'b0;
    ticks(3);
    t_reset();
    prog_en = 1'b1;
    ticks(4);
    t_data_write_then_locked();
    t_erase_sequence();
    t_bad_erase();
    t_reenter_reverse_order();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule